// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This block looks at one 32-bit single-precision floating-point word. It reports whether the word is a NaN, and whether that NaN is signaling. For a signaling NaN it produces a quiet replacement and raises an invalid-operation flag. It is purely combinational and is meant to sit on the operand path of a floating-point unit, ahead of the arithmetic that would consume a NaN.

One mode input selects how the quiet indicator is read. This indicator is the most significant fraction bit. In 2008 mode a set indicator means quiet. In legacy mode a set indicator means signaling. The mode also selects how a signaling NaN is quieted. In 2008 mode the indicator is set, and the sign and payload are kept. In legacy mode the whole word is replaced by a fixed default NaN.

Top module: `fp32_nan_guard`

## Requirements
- R1: `is_nan_o` is 1 when exponent bits [30:23] are all ones and fraction bits [22:0] are not all zero.
- R2: An infinity (exponent all ones, fraction zero) gives `is_nan_o`=0 and `is_snan_o`=0, with either sign.
- R3: A zero, a subnormal or a normal number gives `is_nan_o`=0 and `is_snan_o`=0, and `res_o` equals the operand.
- R4: With `mode_2008_i`=0, a NaN with bit 22 set is signaling and a NaN with bit 22 clear is quiet.
- R5: With `mode_2008_i`=1, a NaN with bit 22 clear is signaling and a NaN with bit 22 set is quiet.
- R6: `invalid_o` is 1 exactly when `is_snan_o` is 1.
- R7: With `mode_2008_i`=1, a signaling NaN yields `res_o` equal to the operand with bit 22 forced to 1. Sign and payload are unchanged.
- R8: With `mode_2008_i`=0, a signaling NaN yields `res_o` = 0x7FBFFFFF, whatever its sign and payload.
- R9: For any operand that is not a signaling NaN, `res_o` equals the operand in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 32 | Operand word: sign [31], exponent [30:23], fraction [22:0] |
| mode_2008_i | input | 1 | 1 selects 2008 NaN encoding, 0 selects legacy encoding |
| is_nan_o | output | 1 | Operand is a NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN under the selected encoding |
| res_o | output | 32 | Quieted value for a signaling NaN, otherwise the operand |
| invalid_o | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The assertions are evaluated whenever an input changes. They check the following on every input combination:
- A signaling NaN is always also reported as a NaN.
- The invalid flag tracks the signaling indication.
- The output passes the operand through when no quieting happens.
- A quieted result is always a quiet NaN under the selected encoding.
- In 2008 mode, quieting leaves every bit except the indicator untouched.

Some behaviours are visible only in the bench's scenarios:
- The exact boundary between NaN and infinity.
- The opposite reading of bit 22 in the two modes.
- The exact legacy default pattern for negative operands and for operands with a full payload.

// File: rtl/fp32_nan_pkg.sv
package fp32_nan_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
endpackage

// File: rtl/fp32_nan_detect.sv
module fp32_nan_detect #(
  parameter int unsigned EXP_W  = fp32_nan_pkg::EXP_W,
  parameter int unsigned FRAC_W = fp32_nan_pkg::FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              mode_2008_i,
  output logic              is_nan_o,
  output logic              is_snan_o
);
  logic exp_max, frac_nz, qbit;

  assign exp_max  = &op_i[FRAC_W +: EXP_W];
  assign frac_nz  = |op_i[FRAC_W-1:0];
  assign qbit     = op_i[FRAC_W-1];
  assign is_nan_o = exp_max & frac_nz;
  // legacy: set bit signals; 2008: clear bit signals
  assign is_snan_o = is_nan_o & (mode_2008_i ^ qbit);

  always_comb begin
    if (!$isunknown({op_i, mode_2008_i})) begin
      a_r1_snan_is_nan: assert (!is_snan_o || is_nan_o)
        else $error("signaling without NaN");
      a_r2_no_nan_on_inf: assert (frac_nz || !is_nan_o)
        else $error("zero fraction flagged as NaN");
    end
  end
endmodule

// File: rtl/fp32_nan_quiet.sv
module fp32_nan_quiet #(
  parameter int unsigned EXP_W  = fp32_nan_pkg::EXP_W,
  parameter int unsigned FRAC_W = fp32_nan_pkg::FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              snan_i,
  input  logic              mode_2008_i,
  output logic [WORD_W-1:0] res_o,
  output logic              invalid_o
);
  // legacy default NaN: positive, exponent max, indicator clear, payload all ones
  localparam logic [WORD_W-1:0] DFLT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic [WORD_W-1:0] quiet_2008;

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_qbit
      if (b == FRAC_W - 1) begin : g_ind
        assign quiet_2008[b] = 1'b1;
      end else begin : g_keep
        assign quiet_2008[b] = op_i[b];
      end
    end
  endgenerate

  always_comb begin
    res_o = op_i;
    if (snan_i) res_o = mode_2008_i ? quiet_2008 : DFLT_NAN;
  end

  assign invalid_o = snan_i;
endmodule

// File: rtl/fp32_nan_guard.sv
module fp32_nan_guard #(
  parameter int unsigned EXP_W  = fp32_nan_pkg::EXP_W,
  parameter int unsigned FRAC_W = fp32_nan_pkg::FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              mode_2008_i,
  output logic              is_nan_o,
  output logic              is_snan_o,
  output logic [WORD_W-1:0] res_o,
  output logic              invalid_o
);
  fp32_nan_detect #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_detect (
    .op_i       (op_i),
    .mode_2008_i(mode_2008_i),
    .is_nan_o   (is_nan_o),
    .is_snan_o  (is_snan_o)
  );

  fp32_nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .op_i       (op_i),
    .snan_i     (is_snan_o),
    .mode_2008_i(mode_2008_i),
    .res_o      (res_o),
    .invalid_o  (invalid_o)
  );

  always_comb begin
    if (!$isunknown({op_i, mode_2008_i})) begin
      a_r6_invalid_tracks_snan: assert (invalid_o == is_snan_o)
        else $error("invalid flag mismatch");
      a_r9_pass_through: assert (is_snan_o || res_o == op_i)
        else $error("non-signaling operand altered");
      a_r7_keep_payload: assert (!(is_snan_o && mode_2008_i) ||
                                 ((res_o ^ op_i) == (WORD_W'(1) << (FRAC_W-1))))
        else $error("2008 quieting changed more than the indicator");
      a_r8_result_quiet: assert (!is_snan_o ||
                                 ((&res_o[FRAC_W +: EXP_W]) && (|res_o[FRAC_W-1:0]) &&
                                  (res_o[FRAC_W-1] == mode_2008_i)))
        else $error("quieted result is not a quiet NaN");
    end
  end
endmodule

// File: tb/fp32_nan_guard_bench.sv
module fp32_nan_guard_bench;
  logic        clk = 1'b0;
  logic [31:0] op;
  logic        mode;
  logic        is_nan, is_snan, inv;
  logic [31:0] res;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fp32_nan_guard u_fp32_nan_guard (
    .op_i(op), .mode_2008_i(mode), .is_nan_o(is_nan),
    .is_snan_o(is_snan), .res_o(res), .invalid_o(inv)
  );

  // {tag, mode, op, nan, snan, res, inv}
  typedef struct packed {
    logic [3:0]  tag;
    logic        md;
    logic [31:0] op;
    logic        nan;
    logic        snan;
    logic [31:0] res;
    logic        inv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 1'b0, 32'h7FC00000, 1'b1, 1'b1, 32'h7FBFFFFF, 1'b1}, // R4 R8
    '{4'd4, 1'b0, 32'h7F800001, 1'b1, 1'b0, 32'h7F800001, 1'b0}, // R4 R9
    '{4'd2, 1'b0, 32'h7F800000, 1'b0, 1'b0, 32'h7F800000, 1'b0}, // R2
    '{4'd3, 1'b0, 32'h3F800000, 1'b0, 1'b0, 32'h3F800000, 1'b0}, // R3
    '{4'd8, 1'b0, 32'hFFC12345, 1'b1, 1'b1, 32'h7FBFFFFF, 1'b1}, // R8 negative
    '{4'd3, 1'b0, 32'h00000001, 1'b0, 1'b0, 32'h00000001, 1'b0}, // R3 subnormal
    '{4'd5, 1'b1, 32'h7FC00000, 1'b1, 1'b0, 32'h7FC00000, 1'b0}, // R5 R9
    '{4'd7, 1'b1, 32'h7F800001, 1'b1, 1'b1, 32'h7FC00001, 1'b1}, // R7 R1
    '{4'd2, 1'b1, 32'hFF800000, 1'b0, 1'b0, 32'hFF800000, 1'b0}, // R2
    '{4'd7, 1'b1, 32'hFFA00005, 1'b1, 1'b1, 32'hFFE00005, 1'b1}, // R7 sign kept
    '{4'd3, 1'b1, 32'h7F7FFFFF, 1'b0, 1'b0, 32'h7F7FFFFF, 1'b0}, // R3 max normal
    '{4'd7, 1'b1, 32'h7FBFFFFF, 1'b1, 1'b1, 32'h7FFFFFFF, 1'b1}, // R7
    '{4'd8, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b1, 32'h7FBFFFFF, 1'b1}, // R8 full payload
    '{4'd3, 1'b1, 32'h00000000, 1'b0, 1'b0, 32'h00000000, 1'b0}  // R3 zero
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input logic md, input logic [31:0] v);
    @(negedge clk);
    mode = md;
    op   = v;
    #1;
  endtask

  initial begin
    op = '0; mode = 1'b0;
    #1;
    chk("R3", "idle is_nan", {31'd0, is_nan}, 32'd0);
    chk("R6", "idle invalid", {31'd0, inv}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      apply(VECS[i].md, VECS[i].op);
      rq = $sformatf("R%0d", VECS[i].tag);
      chk(rq, "is_nan (R1)", {31'd0, is_nan}, {31'd0, VECS[i].nan});
      chk(rq, "is_snan",     {31'd0, is_snan}, {31'd0, VECS[i].snan});
      chk(rq, "res",         res, VECS[i].res);
      chk("R6", "invalid",   {31'd0, inv}, {31'd0, VECS[i].inv});
    end

    // R1: smallest and largest fraction under each mode
    for (int m = 0; m < 2; m++) begin
      apply(m[0], 32'h7F800001);
      chk("R1", "min-frac NaN", {31'd0, is_nan}, 32'd1);
      apply(m[0], 32'hFFFFFFFF);
      chk("R1", "max-frac NaN", {31'd0, is_nan}, 32'd1);
    end

    // R7: walk a single payload bit, 2008 mode, signaling
    for (int b = 0; b < 22; b++) begin
      logic [31:0] v;
      v = 32'h7F800000 | (32'd1 << b);
      apply(1'b1, v);
      chk("R7", "payload walk", res, v | 32'h00400000);
    end

    // R8: same payload walk in legacy with indicator set
    for (int b = 0; b < 22; b++) begin
      apply(1'b0, 32'hFFC00000 | (32'd1 << b));
      chk("R8", "legacy default", res, 32'h7FBFFFFF);
    end

    // R4/R5: the same NaN flips classification with the mode
    apply(1'b0, 32'h7FC00001);
    chk("R4", "legacy set bit", {31'd0, is_snan}, 32'd1);
    apply(1'b1, 32'h7FC00001);
    chk("R5", "2008 set bit", {31'd0, is_snan}, 32'd0);

    // R9: exponent one below max is passed through in both modes
    apply(1'b0, 32'hFF7FFFFF);
    chk("R9", "near-max legacy", res, 32'hFF7FFFFF);
    apply(1'b1, 32'hFF7FFFFF);
    chk("R9", "near-max 2008", res, 32'hFF7FFFFF);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule